// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupts

This block is the control engine of a small memory-to-memory processor. It steps through the instruction cycle one state at a time:

- compute the next instruction address,
- fetch the instruction word,
- decode it,
- compute operand addresses,
- read operands,
- perform the data operation,
- store the result,
- check for an interrupt at the end of each instruction.

States that an opcode does not need are skipped. The operand-address state is revisited once per memory reference of an add. All memory traffic passes through an address register and a buffer register onto a simple request/ready port.

A program counter and an instruction register hold the architectural state. A single shadow register holds the saved return address. The instruction set has four defined opcodes:

- an add that combines two memory words into the first one,
- an unconditional jump,
- a return from the interrupt handler,
- a halt.

Every other opcode completes as a no-op. One interrupt request line is sampled once per instruction. When it is taken, the current program counter is saved, the sequencer vectors to a fixed handler address and further interrupts are masked until the return opcode runs.

Top module: `icyc_sequencer`

## Requirements
- R1: While reset is low, the block issues no request, `halted` is 0 and `int_ack` is 0. After reset is released, the first request is an instruction fetch (`mem_ifetch`=1) from address RESET_PC (default 0).
- R2: Each memory request is a single-cycle pulse on `mem_req`. A `mem_ready` in the same cycle as the request is not counted. A request completes on the first `mem_ready` in a later cycle, and no new request is issued before that.
- R3: After an instruction that does not redirect control, the next fetch address is the previous fetch address plus one, modulo 2^AW. In particular, address 2^AW-1 is followed by 0.
- R4: An instruction word is 16 bits: opcode in bits [15:12], field A in [11:6], field B in [5:0]. Opcode 1 is add, 2 is jump, 3 is return and 15 is halt. Every other opcode makes no data reference and behaves like a no-op.
- R5: Add makes exactly three data references between its fetch and the next fetch, in this order: read A, read B, write A. The value written is (mem[A]+mem[B]) mod 2^16, and it also holds when A equals B.
- R6: Jump makes no data reference, and the next fetch is from field A.
- R7: After a halt is fetched, no further request is issued and `halted` becomes 1 and stays 1 until reset.
- R8: If `irq` is 1 at the end-of-instruction check while interrupts are unmasked: `int_ack` pulses for one cycle, the address the next fetch would have used is saved, interrupts become masked, and the next fetch is from VEC_ADDR (default 0x30).
- R9: While masked, `irq` is ignored: no `int_ack`, and fetching continues as if no request were present.
- R10: Return makes no data reference, makes the next fetch come from the saved address, and unmasks interrupts. The saved address is 0 if no interrupt has been taken since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req | output | 1 | Single-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_ifetch | output | 1 | Request is an instruction fetch |
| mem_addr | output | AW | Request address (address register) |
| mem_wdata | output | 16 | Write data (buffer register) |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completion of the outstanding request |
| irq | input | 1 | Interrupt request level |
| int_ack | output | 1 | One-cycle interrupt acknowledge |
| halted | output | 1 | Sequencer stopped by a halt opcode |

## Verification
The hardest situation to reach is a request that arrives while the handler already runs, followed by a return that must land on the saved address. This needs `irq` to be high exactly across the end-of-instruction check of two consecutive instructions and then low across the return.

The bench drives `irq` once per instruction, at the moment it sees that instruction's fetch, so the level is stable through the following check. A directed program forces the masked case and the return. Random programs with a 30 % request rate reach the other mixtures: a return with nothing saved, jumps into the handler region, an add whose two operands are the same address, and wrap-around of the program counter. Memory latency is random at every request.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  localparam int OPW = 4;

  localparam logic [OPW-1:0] OPC_ADD  = 4'h1;
  localparam logic [OPW-1:0] OPC_JMP  = 4'h2;
  localparam logic [OPW-1:0] OPC_RETI = 4'h3;
  localparam logic [OPW-1:0] OPC_HALT = 4'hF;

  typedef enum logic [3:0] {
    ST_ADDR, ST_FETCH, ST_DECODE, ST_OPADDR, ST_OPREAD,
    ST_EXEC, ST_OPWRITE, ST_IRQCHK, ST_STOP
  } cyc_state_t;

  // which memory reference of a two-operand instruction is under way
  typedef enum logic [1:0] {REF_SRC_A, REF_SRC_B, REF_DST} ref_step_t;

  function automatic logic is_mem_state(cyc_state_t s);
    return (s == ST_FETCH) || (s == ST_OPREAD) || (s == ST_OPWRITE);
  endfunction

endpackage

// File: rtl/icyc_memport.sv
module icyc_memport (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mem_ready,
  output logic mem_req,
  output logic done
);

  logic pending_q;

  assign mem_req = start & ~pending_q;
  assign done    = pending_q & mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending_q <= 1'b0;
    else if (mem_req) pending_q <= 1'b1;
    else if (done)    pending_q <= 1'b0;
  end

  // R2: a request lasts one cycle only
  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

endmodule

// File: rtl/icyc_fsm.sv
module icyc_fsm import icyc_pkg::*; (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  input  logic           mem_done,
  output cyc_state_t     state,
  output ref_step_t      step
);

  cyc_state_t st_d;
  ref_step_t  step_d;

  always_comb begin
    st_d   = state;
    step_d = step;
    unique case (state)
      ST_ADDR:  st_d = ST_FETCH;
      ST_FETCH: if (mem_done) st_d = ST_DECODE;
      ST_DECODE: begin
        step_d = REF_SRC_A;
        case (opcode)
          OPC_ADD:           st_d = ST_OPADDR;
          OPC_JMP, OPC_RETI: st_d = ST_EXEC;
          OPC_HALT:          st_d = ST_STOP;
          default:           st_d = ST_IRQCHK;
        endcase
      end
      ST_OPADDR: st_d = (step == REF_DST) ? ST_OPWRITE : ST_OPREAD;
      ST_OPREAD: if (mem_done) begin
        if (step == REF_SRC_A) begin
          st_d   = ST_OPADDR;
          step_d = REF_SRC_B;
        end else begin
          st_d = ST_EXEC;
        end
      end
      ST_EXEC: if (opcode == OPC_ADD) begin
        st_d   = ST_OPADDR;
        step_d = REF_DST;
      end else begin
        st_d = ST_IRQCHK;
      end
      ST_OPWRITE: if (mem_done) st_d = ST_IRQCHK;
      ST_IRQCHK:  st_d = ST_ADDR;
      ST_STOP:    st_d = ST_STOP;
      default:    st_d = ST_ADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_ADDR;
      step  <= REF_SRC_A;
    end else begin
      state <= st_d;
      step  <= step_d;
    end
  end

  // R2: a memory-touching state waits in place until its reference completes
  assert_wait_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mem_state(state) && !mem_done) |=> (state == $past(state)));

  // R7: the stop state is never left without reset
  assert_stop_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP) |=> (state == ST_STOP));

endmodule

// File: rtl/icyc_sequencer.sv
module icyc_sequencer import icyc_pkg::*; #(
  parameter int             AW       = 6,
  parameter logic [AW-1:0]  RESET_PC = '0,
  parameter logic [AW-1:0]  VEC_ADDR = AW'(48),
  localparam int            DW       = OPW + 2 * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_ifetch,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  input  logic          irq,
  output logic          int_ack,
  output logic          halted
);

  function automatic logic [OPW-1:0] fld_op(logic [DW-1:0] w);
    return w[DW-1 -: OPW];
  endfunction
  function automatic logic [AW-1:0] fld_a(logic [DW-1:0] w);
    return w[2*AW-1 -: AW];
  endfunction
  function automatic logic [AW-1:0] fld_b(logic [DW-1:0] w);
    return w[AW-1:0];
  endfunction
  function automatic logic [DW-1:0] word_sum(logic [DW-1:0] a, logic [DW-1:0] b);
    return a + b;
  endfunction

  cyc_state_t     state;
  ref_step_t      step;
  logic [AW-1:0]  pc_q, mar_q, shadow_q;
  logic [DW-1:0]  ir_q, mbr_q, opa_q;
  logic           masked_q;
  logic [OPW-1:0] opcode;
  logic           mem_done, mem_start;

  // named internal events
  logic fetch_done, irq_take, exec_return;
  assign opcode      = fld_op(ir_q);
  assign fetch_done  = (state == ST_FETCH) && mem_done;
  assign irq_take    = (state == ST_IRQCHK) && irq && !masked_q;
  assign exec_return = (state == ST_EXEC) && (opcode == OPC_RETI);
  assign mem_start   = is_mem_state(state);

  icyc_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode   (opcode),
    .mem_done (mem_done),
    .state    (state),
    .step     (step)
  );

  icyc_memport u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (mem_start),
    .mem_ready (mem_ready),
    .mem_req   (mem_req),
    .done      (mem_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      mar_q    <= '0;
      shadow_q <= '0;
      ir_q     <= '0;
      mbr_q    <= '0;
      opa_q    <= '0;
      masked_q <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: mar_q <= pc_q;
        ST_FETCH: if (mem_done) begin
          ir_q <= mem_rdata;
          pc_q <= pc_q + 1'b1;
        end
        ST_OPADDR: mar_q <= (step == REF_SRC_B) ? fld_b(ir_q) : fld_a(ir_q);
        ST_OPREAD: if (mem_done) begin
          if (step == REF_SRC_A) opa_q <= mem_rdata;
          else                   mbr_q <= mem_rdata;
        end
        ST_EXEC: begin
          if (opcode == OPC_ADD) mbr_q <= word_sum(opa_q, mbr_q);
          if (opcode == OPC_JMP) pc_q  <= fld_a(ir_q);
          if (opcode == OPC_RETI) begin
            pc_q     <= shadow_q;
            masked_q <= 1'b0;
          end
        end
        ST_IRQCHK: if (irq_take) begin
          shadow_q <= pc_q;
          pc_q     <= VEC_ADDR;
          masked_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign mem_addr   = mar_q;
  assign mem_wdata  = mbr_q;
  assign mem_we     = (state == ST_OPWRITE);
  assign mem_ifetch = (state == ST_FETCH);
  assign int_ack    = irq_take;
  assign halted     = (state == ST_STOP);

  // R3: a completed fetch advances the program counter by one
  assert_fetch_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> (pc_q == $past(pc_q) + 1'b1));

  // R8: an acknowledge is followed by masking and the handler address
  assert_ack_vectors_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> (masked_q && pc_q == VEC_ADDR && shadow_q == $past(pc_q)));

  // R9: no acknowledge while masked
  assert_no_ack_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    masked_q |-> !int_ack);

  // R10: return restores the saved address and unmasks
  assert_return_restores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exec_return |=> (!masked_q && pc_q == $past(shadow_q)));

  // R7: once halted, no request and no release
  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_req));

endmodule

// File: tb/test_icyc_sequencer.sv
module test_icyc_sequencer;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 64;
  localparam logic [AW-1:0] VEC = 6'h30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_ready = 1'b0;
  logic irq = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_req, mem_we, mem_ifetch, int_ack, halted;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  always #4 clk = ~clk;  // 125 MHz

  icyc_sequencer i_icyc_sequencer (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ifetch(mem_ifetch), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq(irq),
    .int_ack(int_ack), .halted(halted)
  );

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] q_addr [3];
  logic          q_we [3];
  logic [DW-1:0] q_wd [3];
  int q_n = 0, q_rd = 0;
  logic [AW-1:0] ref_pc, ref_shadow;
  logic ref_mask, ref_halt;
  int exp_acks = 0, seen_acks = 0, instr_cnt = 0, irq_mode = 0, wait_cnt = 0;
  string why = "R1 first fetch after reset";
  logic [DW-1:0] rsp_data = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] bench_add(logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] mk(logic [3:0] op, logic [AW-1:0] a, logic [AW-1:0] b);
    return {op, a, b};
  endfunction

  task automatic push(input logic [AW-1:0] a, input logic we, input logic [DW-1:0] wd);
    q_addr[q_n] = a; q_we[q_n] = we; q_wd[q_n] = wd; q_n++;
  endtask

  // reference step: called at each observed instruction fetch
  task automatic predict(input logic [AW-1:0] faddr);
    logic [DW-1:0] w, s;
    logic [3:0] op;
    logic [AW-1:0] fa, fb;
    logic irq_now;
    check(!ref_halt, "R7 fetch after halt", 32'(faddr), 32'hFFFF);
    check(faddr == ref_pc, why, 32'(faddr), 32'(ref_pc));
    check(seen_acks == exp_acks, "R8/R9 acknowledge count", seen_acks, exp_acks);
    w = ref_mem[ref_pc];
    op = w[15:12]; fa = w[11:6]; fb = w[5:0];
    ref_pc = ref_pc + 1'b1;
    instr_cnt++;
    q_n = 0; q_rd = 0;
    why = "R3 sequential fetch";
    case (irq_mode)
      1: irq_now = ($urandom_range(0, 99) < 30);
      2: irq_now = (instr_cnt <= 2);
      default: irq_now = 1'b0;
    endcase
    irq = irq_now;
    case (op)
      4'h1: begin
        s = bench_add(ref_mem[fa], ref_mem[fb]);
        push(fa, 1'b0, '0); push(fb, 1'b0, '0); push(fa, 1'b1, s);
        ref_mem[fa] = s;
      end
      4'h2: begin ref_pc = fa; why = "R6 jump target"; end
      4'h3: begin ref_pc = ref_shadow; ref_mask = 1'b0; why = "R10 return to saved address"; end
      4'hF: begin ref_halt = 1'b1; return; end
      default: why = "R4 no-op opcode continues sequentially";
    endcase
    if (irq_now && !ref_mask) begin
      ref_shadow = ref_pc; ref_pc = VEC; ref_mask = 1'b1; exp_acks++;
      why = "R8 handler entry";
    end else if (irq_now) begin
      why = {why, " with R9 request masked"};
    end
  endtask

  // memory responder and bus monitor
  initial begin
    forever begin
      bit busy;
      @(negedge clk);
      if (!rst_n) begin
        wait_cnt = 0; mem_ready = 1'b0;
      end else begin
        if (int_ack) seen_acks++;
        busy = (wait_cnt > 0);
        if (wait_cnt > 0) begin
          wait_cnt--;
          mem_ready = (wait_cnt == 0);
          mem_rdata = rsp_data;
        end else begin
          mem_ready = 1'b0;
        end
        if (mem_req) begin
          check(!busy, "R2 request while one is outstanding", 32'(busy), 0);
          if (mem_ifetch) begin
            check(q_rd == q_n, "R5 data references done before next fetch", q_rd, q_n);
            predict(mem_addr);
          end else if (q_rd < q_n) begin
            check(mem_addr == q_addr[q_rd] && mem_we == q_we[q_rd] && (!mem_we || mem_wdata == q_wd[q_rd]),
                  "R5 data reference {we,addr,wdata}",
                  {9'd0, mem_we, mem_addr, mem_wdata}, {9'd0, q_we[q_rd], q_addr[q_rd], q_wd[q_rd]});
            q_rd++;
          end else begin
            check(1'b0, "R5 unexpected data reference address", 32'(mem_addr), 32'hFFFF);
          end
          if (mem_we) mem[mem_addr] = mem_wdata;
          rsp_data = mem[mem_addr];
          wait_cnt = $urandom_range(1, 3);
        end
      end
    end
  end

  task automatic start_run(input int mode);
    @(posedge clk); #2;
    rst_n = 1'b0; irq = 1'b0;
    ref_pc = '0; ref_shadow = '0; ref_mask = 1'b0; ref_halt = 1'b0;
    exp_acks = 0; seen_acks = 0; instr_cnt = 0; q_n = 0; q_rd = 0;
    why = "R1 first fetch after reset"; irq_mode = mode;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = mem[i];
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!mem_req && !halted && !int_ack, "R1 reset outputs {req,halted,ack}",
          {29'd0, mem_req, halted, int_ack}, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
  endtask

  task automatic run_until(input int limit);
    int cyc = 0;
    while (!ref_halt && instr_cnt < limit && cyc < 20000) begin
      @(negedge clk); cyc++;
    end
    check(cyc < 20000, "R3 forward progress", cyc, 20000);
    if (ref_halt) begin
      repeat (30) @(negedge clk);
      check(halted == 1'b1, "R7 halted flag", 32'(halted), 1);
      check(seen_acks == exp_acks, "R8 acknowledge count at halt", seen_acks, exp_acks);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  task automatic random_prog();
    for (int i = 0; i < DEPTH; i++) begin
      int p;
      logic [3:0] op;
      p = $urandom_range(0, 99);
      if (p < 30)      op = 4'h1;
      else if (p < 45) op = 4'h2;
      else if (p < 52) op = 4'h3;
      else if (p < 54) op = 4'hF;
      else if (p < 80) op = 4'(($urandom_range(4, 14)));
      else             op = 4'h0;
      mem[i] = mk(op, 6'($urandom_range(0, 63)), 6'($urandom_range(0, 63)));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // directed: add with carry-out, unused opcode, jump, halt (R4 R5 R6 R7)
    clear_mem();
    mem[0] = mk(4'h1, 6'd10, 6'd11);
    mem[1] = mk(4'h7, 6'd63, 6'd63);
    mem[2] = mk(4'h2, 6'd5, 6'd0);
    mem[5] = mk(4'hF, 6'd0, 6'd0);
    mem[10] = 16'hFFF0; mem[11] = 16'h0025; mem[63] = 16'h1234;
    start_run(0);
    run_until(20);
    check(mem[10] == 16'h0015, "R5 sum wraps modulo 2^16", 32'(mem[10]), 32'h0015);
    check(mem[63] == 16'h1234, "R4 unused opcode leaves memory alone", 32'(mem[63]), 32'h1234);

    // directed: interrupt taken, request while masked, return (R8 R9 R10)
    clear_mem();
    mem[0] = mk(4'h0, 6'd0, 6'd0);
    mem[1] = mk(4'hF, 6'd0, 6'd0);
    mem[6'h30] = mk(4'h0, 6'd0, 6'd0);
    mem[6'h31] = mk(4'h3, 6'd0, 6'd0);
    start_run(2);
    run_until(20);
    check(exp_acks == 1, "R9 single acknowledge in masked handler", exp_acks, 1);

    // directed: same-address add and program counter wrap (R3 R5)
    clear_mem();
    mem[0] = mk(4'h1, 6'd20, 6'd20);
    mem[1] = mk(4'h2, 6'd63, 6'd0);
    mem[63] = mk(4'h9, 6'd0, 6'd0);
    mem[20] = 16'h4001;
    start_run(0);
    run_until(7);

    // constrained random programs with random interrupt requests
    for (int r = 0; r < 40; r++) begin
      random_prog();
      start_run((r % 4 == 0) ? 0 : 1);
      run_until(60);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog R3: actual run still active, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule